// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns single read or write requests from a 16-bit core into timed external memory bus cycles. One 14-bit configuration word, loaded through a write strobe and cleared to zero by reset, selects the bus format (8 or 16 data bits, shared or separate address lines), the number of wait-states, whether an external ready line ends the access and at which level, a long or short address-latch pulse, an optional one-cycle gap before the command strobe, an optional recovery cycle after the access, and whether chip select follows the strobes or spans the whole access.

The core offers a request with `req_valid`. The block takes it on a clock edge where `req_ready` is high. It then steps through address latch, optional delay, command, completion and optional recovery phases. One clock is one timing step. In the completion cycle it pulses `done` and presents any read data on `rd_data`.

Configuration word bit positions: [3:0] wait field, [4] skip-recovery, [5] no-delay, [7:6] format, [8] long latch, [9] bus enable, [10] ready enable, [11] ready level, [12] read-gated select, [13] write-gated select.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: After reset the configuration word is zero. While bit [9] is 0, `req_ready` stays low, no request is taken and every bus output stays inactive (zero).
- R2: The command strobe (`rd_strb` for reads, `wr_strb` for writes) is high for 1 + (15 − W) consecutive cycles, where W is the wait field in bits [3:0]. This count applies when the ready line is not in use.
- R3: When bit [5] is 0, one cycle with no latch and no strobe separates the last `ale` cycle from the first strobe cycle. When bit [5] is 1, the strobe starts in the cycle right after `ale` ends.
- R4: `ale` is high for one cycle when bit [8] is 0 and for two cycles when it is 1. It starts in the cycle after the request is taken.
- R5: When bit [4] is 0, the completion cycle is followed by one recovery cycle in which all bus outputs and `req_ready` are low. When bit [4] is 1, the block is idle again in the next cycle.
- R6: Bit [6] set selects shared lines. In that mode the address is driven on `ad_out` (with `ad_oe` high) during `ale`, then write data is driven, or the lines are released for reads, and `addr_out` stays zero. Bit [6] clear selects separate lines: `addr_out` carries the address from the latch phase through completion, and `ad_out` carries only write data.
- R7: Bit [7] set gives 16 data bits. Bit [7] clear gives 8 data bits: writes drive zero on `ad_out[15:8]`, and read data is the low byte of `ad_in`, zero-extended.
- R8: With bit [10] set, the programmed wait-states run first, with `ready_in` ignored. After that the strobe is held, and `ready_in` is sampled once per clock until it equals bit [11] (0 = low ends the access, 1 = high ends it).
- R9: `done` is a single-cycle pulse in the cycle after the command strobe's last cycle. For reads, `rd_data` in that cycle holds the `ad_in` value sampled in the strobe's last cycle.
- R10: When the select bit for the access direction is set (bit [12] for reads, bit [13] for writes), `cs` is high only in strobe cycles. Otherwise `cs` is high from the first `ale` cycle through the last strobe cycle.
- R11: `rw_dir` is high from the first latch cycle through the completion cycle of a write and low for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Load strobe for the configuration word |
| cfg_wdata | input | 14 | New configuration word |
| req_valid | input | 1 | Core offers an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Block takes a request on this edge |
| done | output | 1 | Access complete pulse |
| rd_data | output | 16 | Read data, valid with `done` |
| ready_in | input | 1 | External ready line |
| ale | output | 1 | Address latch enable |
| rd_strb | output | 1 | Read command strobe, active high |
| wr_strb | output | 1 | Write command strobe, active high |
| rw_dir | output | 1 | Direction of the access in progress |
| cs | output | 1 | Chip select, active high |
| addr_out | output | ADDR_W | Separate address lines |
| ad_out | output | 16 | Shared or data lines, outgoing value |
| ad_oe | output | 1 | Output enable for `ad_out` |
| ad_in | input | 16 | Shared or data lines, incoming value |

## Verification
A wrong phase or counter value inside the sequencer appears at the pins within one clock. A strobe that ends a cycle early or late, an `ale` of the wrong length, or a missing recovery cycle changes the pin pattern in the very cycle where the phase goes wrong. A wrong ready decision shows up as `done` appearing while the ready line is still inactive, or as a strobe that keeps running after the active level. A wrongly captured read value is visible on `rd_data` in the same cycle as `done`.

// File: rtl/bus_ctl_pkg.sv
`timescale 1ns/1ps
package bus_ctl_pkg;

    localparam int WAIT_W = 4;
    localparam int DATA_W = 16;
    localparam int HALF_W = DATA_W / 2;

    // configuration word, bit 0 at the bottom of the struct
    typedef struct packed {
        logic              cs_wr_gate;
        logic              cs_rd_gate;
        logic              rdy_pol;
        logic              rdy_en;
        logic              bus_en;
        logic              ale_long;
        logic [1:0]        fmt;      // [1]=16-bit data, [0]=shared lines
        logic              no_dly;
        logic              no_trn;
        logic [WAIT_W-1:0] wfield;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ALE,
        PH_DLY,
        PH_CMD,
        PH_END,
        PH_TRN
    } phase_e;

endpackage

// File: rtl/bus_cfg_reg.sv
`timescale 1ns/1ps
module bus_cfg_reg
    import bus_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output cfg_t             cfg
);

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d = cfg_t'(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/bus_seq.sv
`timescale 1ns/1ps
module bus_seq
    import bus_ctl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WAIT_W-1:0] wfield,
    input  logic              ale_long,
    input  logic              no_dly,
    input  logic              no_trn,
    input  logic              bus_en,
    input  logic              rdy_en,
    input  logic              rdy_pol,
    input  logic              wide,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ready_in,
    input  logic [DATA_W-1:0] ad_in,
    output phase_e            phase,
    output logic              is_wr,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              req_ready,
    output logic              done
);

    typedef struct packed {
        phase_e            ph;
        logic [WAIT_W-1:0] cnt;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t s_d, s_q;
    logic rdy_hit;
    logic [DATA_W-1:0] rd_fmt;

    assign rdy_hit = !rdy_en || (ready_in == rdy_pol);
    assign rd_fmt  = wide ? ad_in : {{HALF_W{1'b0}}, ad_in[HALF_W-1:0]};

    always_comb begin
        s_d = s_q;
        unique case (s_q.ph)
            PH_IDLE: begin
                if (req_valid && bus_en) begin
                    s_d.ph    = PH_ALE;
                    s_d.cnt   = WAIT_W'(ale_long);
                    s_d.wr    = req_write;
                    s_d.addr  = req_addr;
                    s_d.wdata = req_wdata;
                end
            end
            PH_ALE: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - WAIT_W'(1);
                end else if (no_dly) begin
                    s_d.ph  = PH_CMD;
                    s_d.cnt = ~wfield;
                end else begin
                    s_d.ph = PH_DLY;
                end
            end
            PH_DLY: begin
                s_d.ph  = PH_CMD;
                s_d.cnt = ~wfield;
            end
            PH_CMD: begin
                if (s_q.cnt != '0) begin
                    s_d.cnt = s_q.cnt - WAIT_W'(1);
                end else if (rdy_hit) begin
                    s_d.ph = PH_END;
                    if (!s_q.wr) begin
                        s_d.rdata = rd_fmt;
                    end
                end
            end
            PH_END: begin
                s_d.ph = no_trn ? PH_IDLE : PH_TRN;
            end
            PH_TRN: begin
                s_d.ph = PH_IDLE;
            end
            default: begin
                s_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase     = s_q.ph;
    assign is_wr     = s_q.wr;
    assign addr      = s_q.addr;
    assign wdata     = s_q.wdata;
    assign rdata     = s_q.rdata;
    assign req_ready = (s_q.ph == PH_IDLE) && bus_en;
    assign done      = (s_q.ph == PH_END);

endmodule

// File: rtl/bus_pins.sv
`timescale 1ns/1ps
module bus_pins
    import bus_ctl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  phase_e            phase,
    input  logic              is_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        fmt,
    input  logic              cs_rd_gate,
    input  logic              cs_wr_gate,
    output logic              ale,
    output logic              rd_strb,
    output logic              wr_strb,
    output logic              rw_dir,
    output logic              cs,
    output logic [ADDR_W-1:0] addr_out,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe
);

    logic              busy;
    logic              gated;
    logic              shared;
    logic [DATA_W-1:0] wr_fmt;

    assign busy   = (phase == PH_ALE) || (phase == PH_DLY) ||
                    (phase == PH_CMD) || (phase == PH_END);
    assign gated  = is_wr ? cs_wr_gate : cs_rd_gate;
    assign shared = fmt[0];
    assign wr_fmt = fmt[1] ? wdata : {{HALF_W{1'b0}}, wdata[HALF_W-1:0]};

    always_comb begin
        ale      = (phase == PH_ALE);
        rd_strb  = (phase == PH_CMD) && !is_wr;
        wr_strb  = (phase == PH_CMD) && is_wr;
        rw_dir   = busy && is_wr;
        cs       = (phase == PH_CMD) ||
                   (!gated && ((phase == PH_ALE) || (phase == PH_DLY)));
        addr_out = (busy && !shared) ? addr : '0;
        ad_oe    = 1'b0;
        ad_out   = '0;
        if (phase == PH_ALE && shared) begin
            ad_oe  = 1'b1;
            ad_out = DATA_W'(addr);
        end else if (is_wr && ((phase == PH_ALE) || (phase == PH_DLY) ||
                               (phase == PH_CMD))) begin
            ad_oe  = 1'b1;
            ad_out = wr_fmt;
        end
    end

endmodule

// File: rtl/bus_cycle_ctrl.sv
`timescale 1ns/1ps
module bus_cycle_ctrl
    import bus_ctl_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [13:0]       cfg_wdata,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [15:0]       rd_data,
    input  logic              ready_in,
    output logic              ale,
    output logic              rd_strb,
    output logic              wr_strb,
    output logic              rw_dir,
    output logic              cs,
    output logic [ADDR_W-1:0] addr_out,
    output logic [15:0]       ad_out,
    output logic              ad_oe,
    input  logic [15:0]       ad_in
);

    cfg_t              cfg_q;
    phase_e            phase;
    logic              is_wr;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;

    bus_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .cfg   (cfg_q)
    );

    bus_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wfield    (cfg_q.wfield),
        .ale_long  (cfg_q.ale_long),
        .no_dly    (cfg_q.no_dly),
        .no_trn    (cfg_q.no_trn),
        .bus_en    (cfg_q.bus_en),
        .rdy_en    (cfg_q.rdy_en),
        .rdy_pol   (cfg_q.rdy_pol),
        .wide      (cfg_q.fmt[1]),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ready_in  (ready_in),
        .ad_in     (ad_in),
        .phase     (phase),
        .is_wr     (is_wr),
        .addr      (addr_q),
        .wdata     (wdata_q),
        .rdata     (rd_data),
        .req_ready (req_ready),
        .done      (done)
    );

    bus_pins #(.ADDR_W(ADDR_W)) u_pins (
        .phase      (phase),
        .is_wr      (is_wr),
        .addr       (addr_q),
        .wdata      (wdata_q),
        .fmt        (cfg_q.fmt),
        .cs_rd_gate (cfg_q.cs_rd_gate),
        .cs_wr_gate (cfg_q.cs_wr_gate),
        .ale        (ale),
        .rd_strb    (rd_strb),
        .wr_strb    (wr_strb),
        .rw_dir     (rw_dir),
        .cs         (cs),
        .addr_out   (addr_out),
        .ad_out     (ad_out),
        .ad_oe      (ad_oe)
    );

endmodule

// File: rtl/bus_cycle_ctrl_chk.sv
`timescale 1ns/1ps
module bus_cycle_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic ale,
    input logic rd_strb,
    input logic wr_strb,
    input logic rw_dir,
    input logic cs,
    input logic ad_oe,
    input logic done,
    input logic ready_in,
    input logic rdy_en,
    input logic rdy_pol,
    input logic cs_rd_gate,
    input logic cs_wr_gate
);

    // R4
    ale_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ale) |-> $past(req_valid && req_ready));

    // R3
    ale_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (!rd_strb && !wr_strb));

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_after_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(rd_strb || wr_strb));

    // R8
    ready_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rdy_en) |-> $past(ready_in == rdy_pol));

    // R6
    read_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_strb |-> !ad_oe);

    // R10
    cs_rd_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && cs_rd_gate && !rw_dir) |-> rd_strb);

    // R10
    cs_wr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && cs_wr_gate && rw_dir) |-> wr_strb);

endmodule

bind bus_cycle_ctrl bus_cycle_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .ale        (ale),
    .rd_strb    (rd_strb),
    .wr_strb    (wr_strb),
    .rw_dir     (rw_dir),
    .cs         (cs),
    .ad_oe      (ad_oe),
    .done       (done),
    .ready_in   (ready_in),
    .rdy_en     (cfg_q.rdy_en),
    .rdy_pol    (cfg_q.rdy_pol),
    .cs_rd_gate (cfg_q.cs_rd_gate),
    .cs_wr_gate (cfg_q.cs_wr_gate)
);

// File: tb/tb_bus_cycle_ctrl.sv
`timescale 1ns/1ps
module tb_bus_cycle_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [13:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready;
    logic        done;
    logic [15:0] rd_data;
    logic        ready_in = 1'b0;
    logic        ale, rd_strb, wr_strb, rw_dir, cs, ad_oe;
    logic [15:0] addr_out, ad_out;
    logic [15:0] ad_in = '0;

    always #10 clk = ~clk;

    bus_cycle_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .done(done),
        .rd_data(rd_data), .ready_in(ready_in), .ale(ale), .rd_strb(rd_strb),
        .wr_strb(wr_strb), .rw_dir(rw_dir), .cs(cs), .addr_out(addr_out),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
    );

    typedef struct {
        bit ale, rd, wr, cs, rw, oe, done, rrdy, rdy_act, chk_rd;
        bit [15:0] ad, addr, rdat;
    } exp_t;

    exp_t q[$];
    int   qlen = 0;
    int   n_chk = 0, n_bad = 0, cyc = 0;
    bit   cyc_fail;

    // model of the configuration word
    int       m_ws = 0;
    bit       m_ntrn, m_ndly, m_alel, m_en, m_rdyen, m_pol, m_csr, m_csw;
    bit [1:0] m_fmt;

    // pending stimulus handed to the negedge driver
    bit        p_req = 0, p_wr = 0, p_cfg = 0;
    bit [15:0] p_addr, p_wd, p_adin;
    int        p_extra = 0;
    bit [13:0] p_cfgv;

    function automatic bit [13:0] mk(int ws, bit ntrn, bit ndly, bit [1:0] fmt,
                                     bit alel, bit en, bit rdyen, bit pol,
                                     bit csr, bit csw);
        bit [3:0] w4 = 4'(ws);
        return {csw, csr, pol, rdyen, en, alel, fmt, ndly, ntrn, w4};
    endfunction

    task automatic push_access(bit wr, bit [15:0] a, bit [15:0] wd,
                               bit [15:0] adin, int extra);
        int  waits = 15 - m_ws;
        bit  gate = wr ? m_csw : m_csr;
        bit  shared = m_fmt[0];
        bit [15:0] fd = m_fmt[1] ? wd : {8'h00, wd[7:0]};
        bit [15:0] ao = shared ? 16'h0 : a;
        int  ncmd = waits + 1 + (m_rdyen ? extra : 0);
        exp_t e;
        for (int i = 0; i < (m_alel ? 2 : 1); i++) begin
            e = '{default: '0};
            e.ale = 1; e.cs = !gate; e.rw = wr; e.addr = ao;
            e.oe = shared | wr; e.ad = shared ? a : (wr ? fd : 16'h0);
            q.push_back(e);
        end
        if (!m_ndly) begin
            e = '{default: '0};
            e.cs = !gate; e.rw = wr; e.addr = ao; e.oe = wr;
            e.ad = wr ? fd : 16'h0;
            q.push_back(e);
        end
        for (int i = 0; i < ncmd; i++) begin
            e = '{default: '0};
            e.rd = !wr; e.wr = wr; e.cs = 1; e.rw = wr; e.addr = ao;
            e.oe = wr; e.ad = wr ? fd : 16'h0;
            if (m_rdyen) e.rdy_act = (i < waits) || (i == ncmd - 1);
            q.push_back(e);
        end
        e = '{default: '0};
        e.done = 1; e.rw = wr; e.addr = ao; e.chk_rd = !wr;
        e.rdat = m_fmt[1] ? adin : {8'h00, adin[7:0]};
        q.push_back(e);
        if (!m_ntrn) begin
            e = '{default: '0};
            q.push_back(e);
        end
    endtask

    task automatic cmp(string nm, string rq, logic [15:0] act, logic [15:0] exp);
        if (act !== exp) begin
            cyc_fail = 1;
            $display("FAIL %s %s at cycle %0d: actual=%h expected=%h", rq, nm, cyc, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // compare on every clock, then drive the next inputs
    always @(negedge clk) begin
        if (rst_n) begin
            exp_t e;
            bit was_idle;
            was_idle = (q.size() == 0);
            if (was_idle) begin
                e = '{default: '0};
                e.rrdy = m_en;
            end else begin
                e = q.pop_front();
            end
            cyc_fail = 0;
            n_chk++;
            cmp("req_ready", "R1/R5", 16'(req_ready), 16'(e.rrdy));
            cmp("ale",       "R4",    16'(ale),       16'(e.ale));
            cmp("rd_strb",   "R2/R3/R8", 16'(rd_strb), 16'(e.rd));
            cmp("wr_strb",   "R2/R3/R8", 16'(wr_strb), 16'(e.wr));
            cmp("cs",        "R10",   16'(cs),        16'(e.cs));
            cmp("rw_dir",    "R11",   16'(rw_dir),    16'(e.rw));
            cmp("ad_oe",     "R6",    16'(ad_oe),     16'(e.oe));
            cmp("ad_out",    "R6/R7", ad_out,         e.ad);
            cmp("addr_out",  "R6",    addr_out,       e.addr);
            cmp("done",      "R9",    16'(done),      16'(e.done));
            if (e.chk_rd) cmp("rd_data", "R7/R9", rd_data, e.rdat);
            if (cyc_fail) n_bad++;

            ready_in  = e.rdy_act ? m_pol : ~m_pol;
            req_valid = 0;
            cfg_we    = 0;
            if (was_idle) begin
                if (p_cfg) begin
                    cfg_we = 1; cfg_wdata = p_cfgv;
                    m_ws = int'(p_cfgv[3:0]); m_ntrn = p_cfgv[4];
                    m_ndly = p_cfgv[5]; m_fmt = p_cfgv[7:6];
                    m_alel = p_cfgv[8]; m_en = p_cfgv[9];
                    m_rdyen = p_cfgv[10]; m_pol = p_cfgv[11];
                    m_csr = p_cfgv[12]; m_csw = p_cfgv[13];
                    p_cfg = 0;
                end else if (p_req) begin
                    req_valid = 1; req_write = p_wr; req_addr = p_addr;
                    req_wdata = p_wd; ad_in = p_adin;
                    if (m_en) begin
                        push_access(p_wr, p_addr, p_wd, p_adin, p_extra);
                        p_req = 0;
                    end
                end
            end
            qlen = q.size();
        end
    end

    task automatic set_cfg(bit [13:0] v);
        p_cfgv = v; p_cfg = 1;
        while (p_cfg) @(posedge clk);
    endtask

    task automatic access(bit wr, bit [15:0] a, bit [15:0] wd, bit [15:0] adin, int extra);
        p_wr = wr; p_addr = a; p_wd = wd; p_adin = adin; p_extra = extra;
        p_req = 1;
        while (p_req || qlen != 0) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        // R1: reset state, then a request held while the bus is disabled
        repeat (3) @(posedge clk);
        p_wr = 1; p_addr = 16'h1234; p_wd = 16'hBEEF; p_adin = 0; p_extra = 0;
        p_req = 1;
        repeat (6) @(posedge clk);
        p_req = 0;
        repeat (2) @(posedge clk);

        // R2 R6: 16-bit separate lines, no waits, no delay, no recovery
        set_cfg(mk(15, 1, 1, 2'b10, 0, 1, 0, 0, 0, 0));
        access(1, 16'hA5C3, 16'h1357, 16'h0, 0);
        access(0, 16'h0F0F, 16'h0, 16'hCAFE, 0);

        // R3 R5 R6: 16-bit shared lines, three waits, delay, recovery
        set_cfg(mk(12, 0, 0, 2'b11, 0, 1, 0, 0, 0, 0));
        access(0, 16'h4321, 16'h0, 16'h8642, 0);
        access(1, 16'h7777, 16'h2468, 16'h0, 0);

        // R4 R7: 8-bit shared lines, long latch, fifteen waits
        set_cfg(mk(0, 1, 1, 2'b01, 1, 1, 0, 0, 0, 0));
        access(0, 16'h00FE, 16'h0, 16'hABCD, 0);
        access(1, 16'h0101, 16'h9A5B, 16'h0, 0);

        // R8: ready enabled, high level, one wait, three extra samples
        set_cfg(mk(14, 1, 1, 2'b00, 0, 1, 1, 1, 0, 0));
        access(0, 16'h3C3C, 16'h0, 16'h55AA, 3);
        // R8: low level, ends on first sample
        set_cfg(mk(13, 0, 1, 2'b10, 0, 1, 1, 0, 0, 0));
        access(1, 16'h1111, 16'hF00D, 16'h0, 0);
        access(0, 16'h2222, 16'h0, 16'h1BAD, 2);

        // R10 R11: gated chip select for both directions
        set_cfg(mk(14, 0, 0, 2'b11, 1, 1, 0, 0, 1, 1));
        access(0, 16'h6000, 16'h0, 16'h7E57, 0);
        access(1, 16'h6002, 16'hD00D, 16'h0, 0);
        // R10: reads gated, writes span the access
        set_cfg(mk(15, 1, 0, 2'b10, 0, 1, 0, 0, 1, 0));
        access(1, 16'h0042, 16'h4242, 16'h0, 0);
        access(0, 16'h0044, 16'h0, 16'h0099, 0);

        // R1: disable again and offer a request
        set_cfg(mk(15, 1, 1, 2'b10, 0, 0, 0, 0, 0, 0));
        p_wr = 0; p_addr = 16'h0BAD; p_adin = 16'h1; p_req = 1;
        repeat (5) @(posedge clk);
        p_req = 0;
        repeat (3) @(posedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL R9 watchdog: actual=%0d cycles expected=<20000", cyc);
        finish_run();
    end

endmodule